// File: doc/BRIEF.md
# Dual-Standard Multi-Modulus Frequency Divider

This block is the programmable integer feedback divider of a frequency synthesizer that serves two low-power radio standards. A chain of divide-by-2/3 stages counts cycles of the fast input clock. Each stage takes one program bit and passes a swallow request to the stage before it. All ten stages are active in the high-ratio mode. In the low-ratio mode only the first eight are active: the eighth stage takes the terminal request level, and the two stages above it are held idle. The divider emits one single-cycle pulse per programmed period. This pulse is the feedback edge that the phase detector compares.

The same mode bit also picks the reference clock. Two dividers run from the crystal clock, one dividing by 2 and one dividing by 5, and a 2:1 mux selects between them. Program and mode inputs are sampled into the stage chain only at the end of a complete output period, so a period never mixes two settings.

Top module: `dual_ratio_divider`

## Requirements
- R1: With ratio_hi = 1, the divider period in clk cycles is 1024 + prog[9:0], where prog[0] carries weight 1. This covers the band 1200 to 1240.
- R2: With ratio_hi = 0, the divider period in clk cycles is 256 + prog[7:0], with prog[0] as the least significant bit. This covers the band 480 to 496.
- R3: With ratio_hi = 0, the bits prog[9:8] have no effect on the divider period.
- R4: An all-zero program gives the smallest period of the mode (256 or 1024). An all-ones program gives the largest (511 or 2047).
- R5: A prog change made inside a period leaves that period at the old value, and the following period uses the new value. A change that lands in the last cycle of a period is taken for the very next period.
- R6: A ratio_hi change made inside a period also lets the current period finish at the old mode's ratio before the new mode applies.
- R7: While rst is high, div_pulse and ref_clk are low.
- R8: ref_clk has a rising edge every 5 xtal_clk cycles when ratio_hi = 1, and every 2 xtal_clk cycles when ratio_hi = 0.
- R9: div_pulse is high for exactly one clk cycle per period, in the cycle that follows the last count of the period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock that is being divided |
| xtal_clk | input | 1 | Crystal clock for the reference dividers |
| rst | input | 1 | Synchronous active-high reset, used in both clock domains |
| ratio_hi | input | 1 | 1 selects ten stages and the divide-by-5 reference; 0 selects eight stages and the divide-by-2 reference |
| prog | input | 10 | Program bits; prog[0] belongs to the first stage |
| div_pulse | output | 1 | One-cycle pulse at the end of each divider period |
| ref_clk | output | 1 | Selected divided crystal clock |

## Verification
The collision that matters is a program update arriving in the same cycle as the period boundary. In that cycle the stage chain wraps and the setting is captured. The bench counts the cycles from one pulse and drives a new program exactly one cycle before the next pulse. It then expects the period in progress at the old ratio and the very next period at the new one. Separate tests move prog and ratio_hi well inside a period, which must not disturb the period in progress. Every period is judged by counting clk cycles between pulses against the formula for the sampled mode.

// File: rtl/mmd_pkg.sv
package mmd_pkg;

    localparam int unsigned CELLS_HI   = 10;
    localparam int unsigned CELLS_LO   = 8;
    localparam int unsigned REF_DIV_HI = 5;
    localparam int unsigned REF_DIV_LO = 2;

    // stage count register: 0..2
    typedef logic [1:0] cell_cnt_t;

    // last count of a stage: one extra input cycle when it swallows
    function automatic cell_cnt_t cell_limit(input logic prog_bit, input logic req_n);
        return (prog_bit && !req_n) ? cell_cnt_t'(2) : cell_cnt_t'(1);
    endfunction

endpackage

// File: rtl/mmd_cell.sv
module mmd_cell
    import mmd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic tick_in,
    input  logic prog_bit,
    input  logic req_n_in,
    output logic tick_out,
    output logic req_n_out
);

    cell_cnt_t cnt_q;
    cell_cnt_t limit;
    logic      at_last;

    always_comb begin
        limit   = cell_limit(prog_bit, req_n_in);
        at_last = (cnt_q == limit);
    end

    assign tick_out  = tick_in & at_last;
    assign req_n_out = req_n_in | ~at_last;

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            cnt_q <= '0;
        end else if (tick_in) begin
            cnt_q <= at_last ? cell_cnt_t'(0) : cnt_q + cell_cnt_t'(1);
        end
    end

endmodule

// File: rtl/mmd_chain.sv
module mmd_chain
    import mmd_pkg::*;
#(
    parameter int unsigned N_HI = CELLS_HI,
    parameter int unsigned N_LO = CELLS_LO
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            hi,
    input  logic [N_HI-1:0] prog,
    output logic            bnd,
    output logic            req_n0
);

    logic [N_HI:0]   tick;
    logic [N_HI-1:0] req_n_in;
    logic [N_HI-1:0] req_n_out;
    logic [N_HI-1:0] hold;

    assign tick[0] = 1'b1;

    for (genvar i = 0; i < N_HI; i++) begin : g_stage
        if (i == N_HI - 1) begin : g_term
            assign req_n_in[i] = 1'b0;
        end else if (i == N_LO - 1) begin : g_tap
            assign req_n_in[i] = hi ? req_n_out[i+1] : 1'b0;
        end else begin : g_mid
            assign req_n_in[i] = req_n_out[i+1];
        end

        if (i >= N_LO) begin : g_upper
            assign hold[i] = ~hi;
        end else begin : g_lower
            assign hold[i] = 1'b0;
        end

        mmd_cell u_cell (
            .clk       (clk),
            .rst       (rst),
            .hold      (hold[i]),
            .tick_in   (tick[i]),
            .prog_bit  (prog[i]),
            .req_n_in  (req_n_in[i]),
            .tick_out  (tick[i+1]),
            .req_n_out (req_n_out[i])
        );
    end

    assign bnd    = hi ? tick[N_HI] : tick[N_LO];
    assign req_n0 = req_n_out[0];

endmodule

// File: rtl/ref_div.sv
module ref_div #(
    parameter int unsigned DIV = 2
) (
    input  logic clk,
    input  logic rst,
    output logic q
);

    localparam int unsigned W    = (DIV > 2) ? $clog2(DIV) : 1;
    localparam int unsigned HALF = DIV / 2;

    logic [W-1:0] cnt_q;
    logic         q_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            q_q   <= 1'b0;
        end else begin
            cnt_q <= (cnt_q == W'(DIV - 1)) ? '0 : cnt_q + W'(1);
            q_q   <= (cnt_q < W'(HALF));
        end
    end

    assign q = q_q;

endmodule

// File: rtl/ref_sel.sv
module ref_sel #(
    parameter int unsigned RDIV_HI = 5,
    parameter int unsigned RDIV_LO = 2
) (
    input  logic xtal_clk,
    input  logic rst,
    input  logic hi,
    output logic ref_clk
);

    logic q_hi;
    logic q_lo;

    ref_div #(.DIV(RDIV_HI)) u_div_hi (.clk(xtal_clk), .rst(rst), .q(q_hi));
    ref_div #(.DIV(RDIV_LO)) u_div_lo (.clk(xtal_clk), .rst(rst), .q(q_lo));

    assign ref_clk = hi ? q_hi : q_lo;

endmodule

// File: rtl/dual_ratio_divider.sv
module dual_ratio_divider
    import mmd_pkg::*;
#(
    parameter int unsigned N_HI    = CELLS_HI,
    parameter int unsigned N_LO    = CELLS_LO,
    parameter int unsigned RDIV_HI = REF_DIV_HI,
    parameter int unsigned RDIV_LO = REF_DIV_LO
) (
    input  logic            clk,
    input  logic            xtal_clk,
    input  logic            rst,
    input  logic            ratio_hi,
    input  logic [N_HI-1:0] prog,
    output logic            div_pulse,
    output logic            ref_clk
);

    logic [N_HI-1:0] cfg_prog_q;
    logic            cfg_hi_q;
    logic            bnd;
    logic            req_n0;
    logic            pulse_q;

    // settings enter the chain only when a period closes
    always_ff @(posedge clk) begin
        if (rst || bnd) begin
            cfg_prog_q <= prog;
            cfg_hi_q   <= ratio_hi;
        end
    end

    mmd_chain #(.N_HI(N_HI), .N_LO(N_LO)) u_chain (
        .clk    (clk),
        .rst    (rst),
        .hi     (cfg_hi_q),
        .prog   (cfg_prog_q),
        .bnd    (bnd),
        .req_n0 (req_n0)
    );

    always_ff @(posedge clk) begin
        if (rst) pulse_q <= 1'b0;
        else     pulse_q <= ~req_n0;
    end

    assign div_pulse = pulse_q;

    ref_sel #(.RDIV_HI(RDIV_HI), .RDIV_LO(RDIV_LO)) u_ref (
        .xtal_clk (xtal_clk),
        .rst      (rst),
        .hi       (ratio_hi),
        .ref_clk  (ref_clk)
    );

endmodule

// File: rtl/dual_ratio_divider_chk.sv
module dual_ratio_divider_chk #(
    parameter int unsigned N_HI = 10,
    parameter int unsigned N_LO = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            div_pulse,
    input logic            bnd,
    input logic            cfg_hi,
    input logic [N_HI-1:0] cfg_prog
);

    localparam int unsigned GW = N_HI + 2;
    localparam logic [GW-1:0] GAP_MIN = GW'(1) << N_LO;
    localparam logic [GW-1:0] GAP_MAX = (GW'(1) << (N_HI + 1)) - GW'(1);

    logic [GW-1:0] gap_q;
    logic          seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (div_pulse) begin
            gap_q  <= GW'(1);
            seen_q <= 1'b1;
        end else begin
            gap_q  <= gap_q + GW'(1);
        end
    end

    // R7
    reset_quiet_chk: assert property (@(posedge clk) rst |=> !div_pulse);

    // R9
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        div_pulse |=> !div_pulse);

    // R9
    pulse_align_chk: assert property (@(posedge clk) disable iff (rst)
        bnd |=> div_pulse);

    // R4
    gap_range_chk: assert property (@(posedge clk) disable iff (rst)
        (div_pulse && seen_q) |-> (gap_q >= GAP_MIN && gap_q <= GAP_MAX));

    // R5
    prog_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && !$stable(cfg_prog)) |-> $past(bnd));

    // R6
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && !$stable(cfg_hi)) |-> $past(bnd));

endmodule

bind dual_ratio_divider dual_ratio_divider_chk #(.N_HI(N_HI), .N_LO(N_LO)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .div_pulse (div_pulse),
    .bnd       (bnd),
    .cfg_hi    (cfg_hi_q),
    .cfg_prog  (cfg_prog_q)
);

// File: tb/tb_dual_ratio_divider.sv
module tb_dual_ratio_divider;

    logic       clk = 1'b0;
    logic       xtal_clk = 1'b0;
    logic       rst = 1'b1;
    logic       ratio_hi = 1'b1;
    logic [9:0] prog = 10'd176;
    logic       div_pulse;
    logic       ref_clk;

    int checks = 0;
    int fails  = 0;

    always #2  clk = ~clk;
    always #20 xtal_clk = ~xtal_clk;

    dual_ratio_divider dut (
        .clk       (clk),
        .xtal_clk  (xtal_clk),
        .rst       (rst),
        .ratio_hi  (ratio_hi),
        .prog      (prog),
        .div_pulse (div_pulse),
        .ref_clk   (ref_clk)
    );

    // pulse spacing monitor
    int cyc = 0, last_cyc = 0, last_gap = 0, rise_n = 0;
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (!rst && div_pulse) begin
            last_gap = cyc - last_cyc;
            last_cyc = cyc;
            rise_n   = rise_n + 1;
        end
    end

    // reference edge monitor
    int xcyc = 0, xlast = 0, ref_gap = 0, ref_n = 0;
    logic ref_prev = 1'b0;
    always @(negedge xtal_clk) begin
        xcyc = xcyc + 1;
        if (!rst && ref_clk && !ref_prev) begin
            ref_gap = xcyc - xlast;
            xlast   = xcyc;
            ref_n   = ref_n + 1;
        end
        ref_prev = ref_clk;
    end

    function automatic int exp_ratio(input logic hi, input logic [9:0] p);
        return hi ? 1024 + int'(p) : 256 + int'(p[7:0]);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic get_gap(output int g);
        int c0 = rise_n;
        wait (rise_n != c0);
        g = last_gap;
    endtask

    task automatic get_ref_gap(output int g);
        int c0 = ref_n;
        wait (ref_n != c0);
        g = ref_gap;
    endtask

    task automatic run_ratio(input logic hi, input logic [9:0] p, input string tag);
        int g;
        ratio_hi = hi;
        prog     = p;
        get_gap(g);
        get_gap(g);
        chk(g == exp_ratio(hi, p), tag, g, exp_ratio(hi, p));
    endtask

    task automatic t_reset();
        repeat (40) @(negedge clk);
        chk(div_pulse == 1'b0, "R7 div_pulse in reset", int'(div_pulse), 0);
        chk(ref_clk == 1'b0, "R7 ref_clk in reset", int'(ref_clk), 0);
        rst = 1'b0;
    endtask

    task automatic t_hi_band();
        run_ratio(1'b1, 10'd176, "R1 ratio 1200");
        run_ratio(1'b1, 10'd216, "R1 ratio 1240");
        run_ratio(1'b1, 10'd193, "R1 ratio 1217");
    endtask

    task automatic t_lo_band();
        run_ratio(1'b0, 10'd224, "R2 ratio 480");
        run_ratio(1'b0, 10'd240, "R2 ratio 496");
        run_ratio(1'b0, 10'd233, "R2 ratio 489");
    endtask

    task automatic t_lo_ignore();
        run_ratio(1'b0, 10'h3E0, "R3 upper bits set");
        run_ratio(1'b0, 10'h2E5, "R3 upper bits mixed");
    endtask

    task automatic t_extremes();
        run_ratio(1'b0, 10'h000, "R4 low min");
        run_ratio(1'b0, 10'h0FF, "R4 low max");
        run_ratio(1'b1, 10'h000, "R4 high min");
        run_ratio(1'b1, 10'h3FF, "R4 high max");
    endtask

    task automatic t_pulse_width();
        int g;
        get_gap(g);
        @(negedge clk);
        chk(div_pulse == 1'b0, "R9 pulse one cycle", int'(div_pulse), 0);
    endtask

    task automatic t_prog_mid();
        int g;
        run_ratio(1'b1, 10'd176, "R5 setup");
        repeat (300) @(negedge clk);
        prog = 10'd216;
        get_gap(g);
        chk(g == 1200, "R5 period in progress", g, 1200);
        get_gap(g);
        chk(g == 1240, "R5 next period", g, 1240);
    endtask

    task automatic t_prog_edge();
        int g;
        get_gap(g);
        repeat (1239) @(negedge clk);
        prog = 10'd200;
        get_gap(g);
        chk(g == 1240, "R5 edge period in progress", g, 1240);
        get_gap(g);
        chk(g == 1224, "R5 edge change taken", g, 1224);
    endtask

    task automatic t_mode_mid();
        int g;
        run_ratio(1'b0, 10'h0E0, "R6 setup");
        repeat (50) @(negedge clk);
        ratio_hi = 1'b1;
        get_gap(g);
        chk(g == 480, "R6 period in progress", g, 480);
        get_gap(g);
        chk(g == 1248, "R6 new mode", g, 1248);
    endtask

    task automatic t_ref();
        int g;
        ratio_hi = 1'b1;
        get_ref_gap(g);
        get_ref_gap(g);
        get_ref_gap(g);
        chk(g == 5, "R8 ref divide by 5", g, 5);
        ratio_hi = 1'b0;
        get_ref_gap(g);
        get_ref_gap(g);
        get_ref_gap(g);
        chk(g == 2, "R8 ref divide by 2", g, 2);
    endtask

    initial begin
        t_reset();
        t_hi_band();
        t_lo_band();
        t_lo_ignore();
        t_extremes();
        t_pulse_width();
        t_prog_mid();
        t_prog_edge();
        t_mode_mid();
        t_ref();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule